// File: doc/BRIEF.md
# Indexed Effective Address Generator

This block forms the operand address for the indexed addressing family of a small 8-bit processor. A decoder outside the block supplies a mode code and, for each operation, the chosen 16-bit pointer register value, the two 8-bit accumulators, the program counter and a raw offset. One cycle after a start is accepted, the block presents the effective address with a done pulse. For the auto-increment and auto-decrement modes it also returns the new pointer value with a one-cycle write strobe.

When the indirect flag is set, the computed address is not the result. It names a 16-bit pointer in memory, which the block reads one byte at a time over a request/ready read port. The high byte is read first. The assembled pointer becomes the final address, and done follows the second byte. While an indirect fetch is in progress the block reports busy and ignores new starts.

Top module: `idx_ea_gen`

## Requirements
- R1: Modes 0 (step +1) and 1 (step +2) give the unmodified pointer `base` as the address and return `base` plus the step on `ptr_new`.
- R2: Modes 2 (step -1) and 3 (step -2) subtract the step from `base`, and the result is both the address and `ptr_new`.
- R3: Mode 4 gives `base` unchanged. Mode 5 adds `offset[7:0]` sign-extended and ignores `offset[15:8]`. Mode 6 adds the full 16-bit `offset`.
- R4: Mode 7 adds `acc_a` sign-extended and mode 8 adds `acc_b` sign-extended. Mode 9 adds D = {`acc_a`,`acc_b`}, with `acc_a` as the high byte.
- R5: Mode 10 adds `offset[7:0]` sign-extended to `pc`, and mode 11 adds the 16-bit `offset` to `pc`; `base` is not used.
- R6: All address and pointer arithmetic wraps modulo 65536, including the second indirect byte address.
- R7: A start that is accepted with `indirect`=0 gives `done` high, with `ea` valid, in the very next cycle, for one cycle.
- R8: With `indirect`=1, the block reads the byte at the computed address A and then the byte at A+1. `ea` = {byte(A), byte(A+1)}, and `done` rises in the cycle after the second read handshake.
- R9: `rd_req` stays high with a stable `rd_addr` until a cycle in which `rd_ready` is high. Exactly two handshakes occur per indirect operation.
- R10: `ptr_wr` is high for exactly one cycle per operation, in the cycle after acceptance, and only in modes 0 to 3, whether or not the operation is indirect.
- R11: A `start` while `busy` is high is ignored: it produces no `done`, no `ptr_wr` and no read.
- R12: While and just after reset, `done`, `ptr_wr`, `rd_req` and `busy` are low.
- R13: Mode codes 12 to 15 behave as mode 4 (`base` unchanged, no write-back).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin an operation (accepted when busy is low) |
| mode | input | 4 | Mode code, see requirements |
| indirect | input | 1 | Use the computed address as a pointer location |
| base | input | 16 | Selected pointer register value |
| acc_a | input | 8 | Accumulator A |
| acc_b | input | 8 | Accumulator B |
| pc | input | 16 | Program counter |
| offset | input | 16 | Offset; the low byte is used in 8-bit modes |
| rd_req | output | 1 | Byte read request |
| rd_addr | output | 16 | Byte read address |
| rd_ready | input | 1 | Read completes this cycle |
| rd_data | input | 8 | Read byte, valid with rd_ready |
| busy | output | 1 | Indirect fetch in progress |
| done | output | 1 | Final address valid this cycle |
| ea | output | 16 | Effective address |
| ptr_wr | output | 1 | Pointer write-back strobe |
| ptr_new | output | 16 | Updated pointer value |

## Verification
A corrupted sequencer state in the indirect fetch shows up within one or two handshakes. Symptoms are a request left hanging, a byte read from the wrong address or in the wrong order, or `busy` that never drops. Each of these appears as a wrong `ea` or a missing `done` on the scoreboard in the same operation. A wrong arithmetic or write-back decision appears in the cycle after acceptance, as a mismatching `ea` or `ptr_new`, or as a strobe that is missing or extra.

// File: rtl/idx_ea_pkg.sv
package idx_ea_pkg;

    localparam int ADDR_W = 16;
    localparam int BYTE_W = 8;
    localparam int MODE_W = 4;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic [MODE_W-1:0] {
        M_INC1  = 4'd0,
        M_INC2  = 4'd1,
        M_DEC1  = 4'd2,
        M_DEC2  = 4'd3,
        M_ZERO  = 4'd4,
        M_OFF8  = 4'd5,
        M_OFF16 = 4'd6,
        M_ACCA  = 4'd7,
        M_ACCB  = 4'd8,
        M_ACCD  = 4'd9,
        M_PC8   = 4'd10,
        M_PC16  = 4'd11
    } ea_mode_e;

    typedef struct packed {
        addr_t addr;
        addr_t ptr;
        logic  wb;
    } ea_calc_t;

    typedef enum logic [1:0] {
        F_IDLE,
        F_HI,
        F_LO
    } fetch_st_e;

    typedef enum logic {
        T_IDLE,
        T_WAIT
    } top_st_e;

    function automatic addr_t sext8(input byte_t v);
        return {{(ADDR_W-BYTE_W){v[BYTE_W-1]}}, v};
    endfunction

    function automatic addr_t step_of(input logic two);
        return two ? addr_t'(2) : addr_t'(1);
    endfunction

endpackage

// File: rtl/idx_addr_calc.sv
module idx_addr_calc
    import idx_ea_pkg::*;
(
    input  logic [MODE_W-1:0] mode,
    input  addr_t             base,
    input  byte_t             acc_a,
    input  byte_t             acc_b,
    input  addr_t             pc,
    input  addr_t             offset,
    output ea_calc_t          res
);

    addr_t step;
    addr_t dec_val;

    assign step    = step_of(mode[0]);
    assign dec_val = base - step;

    always_comb begin
        res.addr = base;
        res.ptr  = base;
        res.wb   = 1'b0;
        case (ea_mode_e'(mode))
            M_INC1, M_INC2: begin
                res.ptr = base + step;
                res.wb  = 1'b1;
            end
            M_DEC1, M_DEC2: begin
                res.addr = dec_val;
                res.ptr  = dec_val;
                res.wb   = 1'b1;
            end
            M_OFF8:  res.addr = base + sext8(offset[BYTE_W-1:0]);
            M_OFF16: res.addr = base + offset;
            M_ACCA:  res.addr = base + sext8(acc_a);
            M_ACCB:  res.addr = base + sext8(acc_b);
            M_ACCD:  res.addr = base + {acc_a, acc_b};
            M_PC8:   res.addr = pc + sext8(offset[BYTE_W-1:0]);
            M_PC16:  res.addr = pc + offset;
            default: ;
        endcase
    end

endmodule

// File: rtl/idx_ind_fetch.sv
module idx_ind_fetch
    import idx_ea_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  go,
    input  addr_t ptr_loc,
    input  logic  rd_ready,
    input  byte_t rd_data,
    output logic  rd_req,
    output addr_t rd_addr,
    output logic  last,
    output addr_t value
);

    fetch_st_e st;
    addr_t     loc_q;
    byte_t     hi_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= F_IDLE;
            loc_q <= '0;
            hi_q  <= '0;
        end else begin
            case (st)
                F_IDLE: if (go) begin
                    loc_q <= ptr_loc;
                    st    <= F_HI;
                end
                F_HI: if (rd_ready) begin
                    hi_q <= rd_data;
                    st   <= F_LO;
                end
                F_LO: if (rd_ready) st <= F_IDLE;
                default: st <= F_IDLE;
            endcase
        end
    end

    assign rd_req  = (st != F_IDLE);
    assign rd_addr = (st == F_LO) ? loc_q + addr_t'(1) : loc_q;
    assign last    = (st == F_LO) && rd_ready;
    assign value   = {hi_q, rd_data};

endmodule

// File: rtl/idx_ea_gen.sv
module idx_ea_gen
    import idx_ea_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic [3:0]  mode,
    input  logic        indirect,
    input  logic [15:0] base,
    input  logic [7:0]  acc_a,
    input  logic [7:0]  acc_b,
    input  logic [15:0] pc,
    input  logic [15:0] offset,
    output logic        rd_req,
    output logic [15:0] rd_addr,
    input  logic        rd_ready,
    input  logic [7:0]  rd_data,
    output logic        busy,
    output logic        done,
    output logic [15:0] ea,
    output logic        ptr_wr,
    output logic [15:0] ptr_new
);

    top_st_e  st;
    ea_calc_t calc;
    logic     accept;
    logic     f_last;
    addr_t    f_value;
    logic     done_q;
    logic     wr_q;
    addr_t    ea_q;
    addr_t    ptr_q;

    assign accept = start && (st == T_IDLE);

    idx_addr_calc u_calc (
        .mode   (mode),
        .base   (base),
        .acc_a  (acc_a),
        .acc_b  (acc_b),
        .pc     (pc),
        .offset (offset),
        .res    (calc)
    );

    idx_ind_fetch u_fetch (
        .clk      (clk),
        .rst      (rst),
        .go       (accept && indirect),
        .ptr_loc  (calc.addr),
        .rd_ready (rd_ready),
        .rd_data  (rd_data),
        .rd_req   (rd_req),
        .rd_addr  (rd_addr),
        .last     (f_last),
        .value    (f_value)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= T_IDLE;
            done_q <= 1'b0;
            wr_q   <= 1'b0;
            ea_q   <= '0;
            ptr_q  <= '0;
        end else begin
            done_q <= 1'b0;
            wr_q   <= 1'b0;
            if (accept) begin
                wr_q  <= calc.wb;
                ptr_q <= calc.ptr;
                if (indirect) begin
                    st <= T_WAIT;
                end else begin
                    done_q <= 1'b1;
                    ea_q   <= calc.addr;
                end
            end
            if (st == T_WAIT && f_last) begin
                done_q <= 1'b1;
                ea_q   <= f_value;
                st     <= T_IDLE;
            end
        end
    end

    assign busy    = (st == T_WAIT);
    assign done    = done_q;
    assign ea      = ea_q;
    assign ptr_wr  = wr_q;
    assign ptr_new = ptr_q;

endmodule

// File: rtl/idx_ea_chk.sv
module idx_ea_chk (
    input logic        clk,
    input logic        rst,
    input logic        start,
    input logic [3:0]  mode,
    input logic        indirect,
    input logic [15:0] base,
    input logic        busy,
    input logic        done,
    input logic [15:0] ea,
    input logic        ptr_wr,
    input logic [15:0] ptr_new,
    input logic        rd_req,
    input logic        rd_ready,
    input logic [15:0] rd_addr
);

    // R1: post-increment address is the untouched pointer
    a_r1_postinc_addr: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && !indirect && mode <= 4'd1) |=> (ea == $past(base)));

    // R2: pre-decrement address equals the written-back pointer
    a_r2_predec_match: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && !indirect && (mode == 4'd2 || mode == 4'd3))
        |=> (ptr_wr && done && ea == ptr_new));

    // R7: direct result one cycle after acceptance
    a_r7_direct_done: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && !indirect) |=> done);

    // R9: request held with stable address until ready
    a_r9_req_hold: assert property (@(posedge clk) disable iff (rst)
        (rd_req && !rd_ready) |=> (rd_req && $stable(rd_addr)));

    // R10: no write-back for the non-stepping modes
    a_r10_wr_only_step: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && mode >= 4'd4) |=> !ptr_wr);

    // R10: stepping modes always write back
    a_r10_wr_step: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && mode <= 4'd3) |=> ptr_wr);

    // R11: a start while busy causes no write-back
    a_r11_busy_ignored: assert property (@(posedge clk) disable iff (rst)
        (start && busy) |=> !ptr_wr);

    // R12: no read traffic outside an indirect fetch
    a_r12_idle_no_req: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !rd_req);

endmodule

bind idx_ea_gen idx_ea_chk u_chk (.*);

// File: tb/idx_ea_gen_bench.sv
`timescale 1ns/1ps
module idx_ea_gen_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic [3:0]  mode;
    logic        indirect;
    logic [15:0] base, pc, offset;
    logic [7:0]  acc_a, acc_b;
    logic        rd_req, rd_ready, busy, done, ptr_wr;
    logic [15:0] rd_addr, ea, ptr_new;
    logic [7:0]  rd_data;

    int total = 0;
    int bad = 0;
    int done_seen = 0;
    int ops_sent = 0;
    bit finished = 0;

    logic [15:0] ea_q[$];
    string       ea_tag_q[$];
    logic [15:0] wb_q[$];
    string       wb_tag_q[$];

    always #2 clk = ~clk;

    idx_ea_gen u_idx_ea_gen (
        .clk(clk), .rst(rst), .start(start), .mode(mode), .indirect(indirect),
        .base(base), .acc_a(acc_a), .acc_b(acc_b), .pc(pc), .offset(offset),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_ready(rd_ready), .rd_data(rd_data),
        .busy(busy), .done(done), .ea(ea), .ptr_wr(ptr_wr), .ptr_new(ptr_new)
    );

    function automatic logic [7:0] mem_byte(input logic [15:0] a);
        return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'hA5;
    endfunction

    function automatic logic [15:0] sx(input logic [7:0] v);
        return {{8{v[7]}}, v};
    endfunction

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // memory responder: variable wait before each ready
    initial begin
        int nreq = 0;
        int wait_left = 0;
        rd_ready = 1'b0;
        rd_data = '0;
        forever begin
            @(negedge clk);
            if (rd_ready) rd_ready = 1'b0;
            else if (rd_req) begin
                if (wait_left == 0) begin
                    rd_ready = 1'b1;
                    rd_data = mem_byte(rd_addr);
                    nreq++;
                    wait_left = nreq % 3;
                end else wait_left--;
            end
        end
    end

    // monitor: pops expected results
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && done) begin
                done_seen++;
                if (ea_q.size() == 0) check("R11 unexpected done", 16'h1, 16'h0);
                else check(ea_tag_q.pop_front(), ea, ea_q.pop_front());
            end
            if (!rst && ptr_wr) begin
                if (wb_q.size() == 0) check("R10 unexpected ptr_wr", 16'h1, 16'h0);
                else check(wb_tag_q.pop_front(), ptr_new, wb_q.pop_front());
            end
        end
    end

    task automatic launch(input logic [3:0] m, input logic ind, input logic [15:0] b,
                          input logic [7:0] a, input logic [7:0] bb,
                          input logic [15:0] p, input logic [15:0] o, input string tag);
        logic [15:0] ad, pn;
        logic wb;
        ad = b; pn = b; wb = 1'b0;
        case (m)
            4'd0: begin pn = b + 16'd1; wb = 1'b1; end
            4'd1: begin pn = b + 16'd2; wb = 1'b1; end
            4'd2: begin ad = b - 16'd1; pn = ad; wb = 1'b1; end
            4'd3: begin ad = b - 16'd2; pn = ad; wb = 1'b1; end
            4'd5: ad = b + sx(o[7:0]);
            4'd6: ad = b + o;
            4'd7: ad = b + sx(a);
            4'd8: ad = b + sx(bb);
            4'd9: ad = b + {a, bb};
            4'd10: ad = p + sx(o[7:0]);
            4'd11: ad = p + o;
            default: ;
        endcase
        if (ind) ad = {mem_byte(ad), mem_byte(ad + 16'd1)};
        @(negedge clk);
        mode = m; indirect = ind; base = b; acc_a = a; acc_b = bb; pc = p; offset = o;
        start = 1'b1;
        ea_q.push_back(ad);
        ea_tag_q.push_back({tag, " ea"});
        if (wb) begin
            wb_q.push_back(pn);
            wb_tag_q.push_back({tag, " ptr_new R10"});
        end
        ops_sent++;
        @(negedge clk);
        start = 1'b0;
        if (!ind) check({tag, " R7 done latency"}, {15'd0, done}, 16'd1);
    endtask

    task automatic drain();
        while (ea_q.size() != 0 || wb_q.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic run(input logic [3:0] m, input logic ind, input logic [15:0] b,
                       input logic [7:0] a, input logic [7:0] bb,
                       input logic [15:0] p, input logic [15:0] o, input string tag);
        launch(m, ind, b, a, bb, p, o, tag);
        drain();
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; start = 1'b0; mode = '0; indirect = 1'b0;
        base = '0; acc_a = '0; acc_b = '0; pc = '0; offset = '0;
        repeat (3) @(negedge clk);
        check("R12 reset outputs", {12'd0, done, ptr_wr, rd_req, busy}, 16'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R12 after reset", {12'd0, done, ptr_wr, rd_req, busy}, 16'd0);

        run(4'd0, 0, 16'h1234, 8'h00, 8'h00, 16'h0, 16'h0, "R1 inc1");
        run(4'd1, 0, 16'h2000, 8'h00, 8'h00, 16'h0, 16'h0, "R1 inc2");
        run(4'd1, 0, 16'hFFFF, 8'h00, 8'h00, 16'h0, 16'h0, "R6 inc2 wrap");
        run(4'd2, 0, 16'h3000, 8'h00, 8'h00, 16'h0, 16'h0, "R2 dec1");
        run(4'd3, 0, 16'h0000, 8'h00, 8'h00, 16'h0, 16'h0, "R6 dec2 wrap");
        run(4'd3, 0, 16'h4005, 8'h00, 8'h00, 16'h0, 16'h0, "R2 dec2");
        run(4'd4, 0, 16'h5A5A, 8'h11, 8'h22, 16'h9999, 16'h7777, "R3 zero");
        run(4'd5, 0, 16'h1000, 8'h00, 8'h00, 16'h0, 16'h12F9, "R3 off8 neg");
        run(4'd5, 0, 16'h1000, 8'h00, 8'h00, 16'h0, 16'hFF7F, "R3 off8 pos");
        run(4'd6, 0, 16'hF000, 8'h00, 8'h00, 16'h0, 16'h2345, "R3 off16");
        run(4'd7, 0, 16'h0100, 8'h80, 8'h7F, 16'h0, 16'h0, "R4 acc a");
        run(4'd8, 0, 16'h0100, 8'h80, 8'h7F, 16'h0, 16'h0, "R4 acc b");
        run(4'd9, 0, 16'h0100, 8'h80, 8'h7F, 16'h0, 16'h0, "R4 acc d");
        run(4'd10, 0, 16'hAAAA, 8'h00, 8'h00, 16'h0010, 16'h00F0, "R5 pc8");
        run(4'd11, 0, 16'hAAAA, 8'h00, 8'h00, 16'hC000, 16'h8001, "R5 pc16");
        run(4'd13, 0, 16'h6789, 8'h01, 8'h02, 16'h0003, 16'h0004, "R13 spare code");
        run(4'd15, 0, 16'h0042, 8'h01, 8'h02, 16'h0003, 16'h0004, "R13 spare code 15");

        run(4'd4, 1, 16'h0800, 8'h00, 8'h00, 16'h0, 16'h0, "R8 ind zero");
        run(4'd0, 1, 16'h0900, 8'h00, 8'h00, 16'h0, 16'h0, "R8 ind inc1");
        run(4'd3, 1, 16'h0A00, 8'h00, 8'h00, 16'h0, 16'h0, "R8 ind dec2");
        run(4'd9, 1, 16'h0100, 8'h12, 8'h34, 16'h0, 16'h0, "R8 ind acc d");
        run(4'd4, 1, 16'hFFFF, 8'h00, 8'h00, 16'h0, 16'h0, "R6 ind wrap");
        run(4'd11, 1, 16'h0, 8'h00, 8'h00, 16'h7000, 16'h0123, "R9 ind pc16");

        // R11: start during an indirect fetch is dropped
        launch(4'd6, 1, 16'h2222, 8'h00, 8'h00, 16'h0, 16'h0101, "R11 base op");
        check("R11 busy during fetch", {15'd0, busy}, 16'd1);
        mode = 4'd0; indirect = 1'b0; base = 16'h4444; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R11 no strobe", {14'd0, ptr_wr, done}, 16'd0);
        drain();
        repeat (4) @(negedge clk);
        check("R11 done count", 16'(done_seen), 16'(ops_sent));
        check("R9 queues empty", 16'(ea_q.size() + wb_q.size()), 16'd0);
        check("R12 idle at end", {14'd0, busy, rd_req}, 16'd0);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule